// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a common-I/O SRAM that moves data in bursts of two beats. Commands (a load strobe, a read/write select and a word address) are sampled on a command clock. Write beats arrive on a second clock with the same frequency and a fixed phase lag. Each burst is kept as one word twice as wide as a beat, so the address port is one bit narrower than the beat depth would need.

Both edges of a real double-data-rate bus are modelled here as two parallel beat ports that are updated once per cycle. A read fetches one wide word and returns its halves on the two read-beat ports after a latency of two or three cycles. The latency is chosen by a configuration pin that is captured only while reset is held. A write is committed to the array one cycle after its command. A read that comes right after a write to the same word still gets the new data, because the pending word is forwarded to the read.

Top module: `ddr2b_sram`

## Requirements
- R1: While `rd_valid` is low, `rd_beat0` and `rd_beat1` are all zeros. This holds from reset until the first read result appears.
- R2: A write is a `cmd_clk` rising edge that samples `cmd_ld`=1 and `cmd_rw`=0. Its beats are taken from `wr_beat0`/`wr_beat1` on the first `dat_clk` rising edge after that command edge, where `dat_clk` lags `cmd_clk` by less than one period. Both beats are stored together as one word, with beat 0 in the low half.
- R3: A read is a `cmd_clk` edge that samples `cmd_ld`=1 and `cmd_rw`=1. It returns the low half of the addressed word on `rd_beat0` and the high half on `rd_beat1`.
- R4: Let the read be sampled on edge N. The result and `rd_valid` appear just after edge N+2 when latency 2 is selected (`cfg_rl3`=0), and just after edge N+3 when latency 3 is selected (`cfg_rl3`=1).
- R5: `rd_valid` is high for exactly one command cycle per read, which covers both beat slots. Reads on back-to-back edges give valid results in consecutive cycles, in issue order.
- R6: Reads see writes coherently. A read issued in the cycle right after a write to the same address returns the new data, and of two writes in a row to the same address the later one wins.
- R7: When `cmd_ld`=0 on an edge, nothing happens: no word is written and no read result is produced, whatever `cmd_rw`, the address and the beats hold.
- R8: While `rst` is high, read and write commands are ignored. The array keeps its contents and no read result appears.
- R9: `cfg_rl3` is captured only on edges where `rst` is high. Changing it while out of reset has no effect on latency.
- R10: `cmd_addr` is log2(BEAT_DEPTH/2) bits wide, and every address, including the lowest and the highest, selects its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cmd_clk | input | 1 | Command clock; clocks commands, the array and the read path |
| dat_clk | input | 1 | Write-data clock, same frequency, lagging phase |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rl3 | input | 1 | Latency select captured in reset: 1 = three cycles, 0 = two |
| cmd_ld | input | 1 | Command strobe; 0 is a no-operation |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Wide-word address |
| wr_beat0 | input | BEAT_W | First write beat (low half) |
| wr_beat1 | input | BEAT_W | Second write beat (high half) |
| rd_valid | output | 1 | High in the cycle that carries a read result |
| rd_beat0 | output | BEAT_W | First read beat (low half) |
| rd_beat1 | output | BEAT_W | Second read beat (high half) |

## Verification
Some internal faults show up at the read ports only when the affected word is read back. A lost or misplaced array write, a swapped beat half, or a missing forward of a pending write is seen the first time that word is read. It then appears exactly latency cycles after the read edge. A wrongly captured or wrongly selected latency shifts every `rd_valid` pulse by one cycle, so the first read after reset already exposes it. The bench compares the outputs against a queue-based model on every command cycle.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_WR  = 2'd1,
        CMD_RD  = 2'd2
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic rst, input logic ld, input logic rw);
        if (rst || !ld) begin
            return CMD_NOP;
        end
        return rw ? CMD_RD : CMD_WR;
    endfunction

endpackage

// File: rtl/ddr2b_wcap.sv
module ddr2b_wcap #(
    parameter int BEAT_W = 18,
    localparam int WORD_W = 2 * BEAT_W
) (
    input  logic              dat_clk,
    input  logic              rst,
    input  logic [BEAT_W-1:0] beat0_i,
    input  logic [BEAT_W-1:0] beat1_i,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.word = {beat1_i, beat0_i};
        if (rst) begin
            cap_d = '0;
        end
    end

    always_ff @(posedge dat_clk) begin
        cap_q <= cap_d;
    end

    assign word_o = cap_q.word;

endmodule

// File: rtl/ddr2b_array.sv
module ddr2b_array
    import ddr2b_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 4,
    localparam int WORD_DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wword_i,
    output logic [WORD_W-1:0] fetch_o
);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
    } wr_t;

    wr_t wr_d, wr_q;

    logic [WORD_W-1:0] mem [WORD_DEPTH];
    logic              commit;
    logic              hit;

    always_comb begin
        commit  = wr_q.pend && !rst;
        hit     = commit && (wr_q.addr == addr_i);
        fetch_o = hit ? wword_i : mem[addr_i];

        wr_d      = wr_q;
        wr_d.pend = (cmd_i == CMD_WR);
        if (cmd_i == CMD_WR) begin
            wr_d.addr = addr_i;
        end
        if (rst) begin
            wr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        wr_q <= wr_d;
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            mem[wr_q.addr] <= wword_i;
        end
    end

    AST_BYPASS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (hit && cmd_i == CMD_RD) |=> (mem[$past(addr_i)] == $past(fetch_o))); // R6

endmodule

// File: rtl/ddr2b_rdpipe.sv
module ddr2b_rdpipe #(
    parameter int WORD_W   = 36,
    parameter int RL_SHORT = 2,
    parameter int RL_LONG  = 3,
    localparam int DEPTH   = RL_LONG,
    localparam int TAP_S   = RL_SHORT - 1,
    localparam int TAP_L   = RL_LONG - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_rl3_i,
    input  logic              issue_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic                          rl3;
        logic [DEPTH-1:0]              v;
        logic [DEPTH-1:0][WORD_W-1:0]  d;
        logic                          ov;
        logic [WORD_W-1:0]             od;
    } pipe_t;

    pipe_t p_d, p_q;
    logic  tap_v;
    logic [WORD_W-1:0] tap_d;

    always_comb begin
        tap_v = p_q.rl3 ? p_q.v[TAP_L] : p_q.v[TAP_S];
        tap_d = p_q.rl3 ? p_q.d[TAP_L] : p_q.d[TAP_S];

        p_d      = p_q;
        p_d.v[0] = issue_i;
        p_d.d[0] = word_i;
        for (int k = 1; k < DEPTH; k++) begin
            p_d.v[k] = p_q.v[k-1];
            p_d.d[k] = p_q.d[k-1];
        end
        p_d.ov = tap_v;
        p_d.od = tap_v ? tap_d : '0;

        if (rst) begin
            p_d     = '0;
            p_d.rl3 = cfg_rl3_i;
        end
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
    end

    assign valid_o = p_q.ov;
    assign word_o  = p_q.od;

    AST_LAT_SHORT: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !p_q.rl3) |-> ##(RL_SHORT + 1) valid_o); // R4
    AST_LAT_LONG: assert property (@(posedge clk) disable iff (rst)
        (issue_i && p_q.rl3) |-> ##(RL_LONG + 1) valid_o); // R4
    AST_RL_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(p_q.rl3)); // R9

endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
    import ddr2b_pkg::*;
#(
    parameter int BEAT_W     = 18,
    parameter int BEAT_DEPTH = 32,
    parameter int RL_SHORT   = 2,
    parameter int RL_LONG    = 3,
    localparam int WORD_W    = 2 * BEAT_W,
    localparam int ADDR_W    = $clog2(BEAT_DEPTH / 2)
) (
    input  logic              cmd_clk,
    input  logic              dat_clk,
    input  logic              rst,
    input  logic              cfg_rl3,
    input  logic              cmd_ld,
    input  logic              cmd_rw,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BEAT_W-1:0] wr_beat0,
    input  logic [BEAT_W-1:0] wr_beat1,
    output logic              rd_valid,
    output logic [BEAT_W-1:0] rd_beat0,
    output logic [BEAT_W-1:0] rd_beat1
);

    cmd_e              cmd;
    logic [WORD_W-1:0] wword;
    logic [WORD_W-1:0] fetch;
    logic [WORD_W-1:0] rword;

    always_comb begin
        cmd = decode_cmd(rst, cmd_ld, cmd_rw);
    end

    ddr2b_wcap #(
        .BEAT_W (BEAT_W)
    ) wcap_i (
        .dat_clk (dat_clk),
        .rst     (rst),
        .beat0_i (wr_beat0),
        .beat1_i (wr_beat1),
        .word_o  (wword)
    );

    ddr2b_array #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) array_i (
        .clk     (cmd_clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .addr_i  (cmd_addr),
        .wword_i (wword),
        .fetch_o (fetch)
    );

    ddr2b_rdpipe #(
        .WORD_W   (WORD_W),
        .RL_SHORT (RL_SHORT),
        .RL_LONG  (RL_LONG)
    ) rdpipe_i (
        .clk       (cmd_clk),
        .rst       (rst),
        .cfg_rl3_i (cfg_rl3),
        .issue_i   (cmd == CMD_RD),
        .word_i    (fetch),
        .valid_o   (rd_valid),
        .word_o    (rword)
    );

    assign rd_beat0 = rword[BEAT_W-1:0];
    assign rd_beat1 = rword[WORD_W-1:BEAT_W];

    AST_IDLE_ZERO: assert property (@(posedge cmd_clk) disable iff (rst)
        !rd_valid |-> (rd_beat0 == '0 && rd_beat1 == '0)); // R1
    AST_RESET_QUIET: assert property (@(posedge cmd_clk)
        rst |=> !rd_valid); // R8

endmodule

// File: tb/ddr2b_sram_tb_top.sv
module ddr2b_sram_tb_top;

    localparam int BW = 18;
    localparam int BD = 32;
    localparam int AW = 4;
    localparam int WW = 2 * BW;

    logic          cmd_clk  = 1'b0;
    logic          dat_clk  = 1'b0;
    logic          rst      = 1'b1;
    logic          cfg_rl3  = 1'b0;
    logic          cmd_ld   = 1'b0;
    logic          cmd_rw   = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [BW-1:0] wr_beat0 = '0;
    logic [BW-1:0] wr_beat1 = '0;
    logic          rd_valid;
    logic [BW-1:0] rd_beat0;
    logic [BW-1:0] rd_beat1;

    ddr2b_sram #(.BEAT_W(BW), .BEAT_DEPTH(BD)) dut_i (
        .cmd_clk (cmd_clk), .dat_clk (dat_clk), .rst (rst), .cfg_rl3 (cfg_rl3),
        .cmd_ld (cmd_ld), .cmd_rw (cmd_rw), .cmd_addr (cmd_addr),
        .wr_beat0 (wr_beat0), .wr_beat1 (wr_beat1),
        .rd_valid (rd_valid), .rd_beat0 (rd_beat0), .rd_beat1 (rd_beat1)
    );

    always #5 cmd_clk = ~cmd_clk;
    initial begin
        #3;
        forever #5 dat_clk = ~dat_clk;
    end

    int cyc = 0;
    always @(posedge cmd_clk) cyc <= cyc + 1;

    logic [WW-1:0] mem_m [int];
    bit            exp_v [int];
    logic [WW-1:0] exp_d [int];
    int    rl_m   = 2;
    bit    rst_m  = 1'b1;
    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    done   = 1'b0;

    // Per-cycle comparison against the reference model
    always @(negedge cmd_clk) begin
        bit            ev;
        logic [WW-1:0] ed;
        if (!done) begin
            ev = exp_v.exists(cyc) ? exp_v[cyc] : 1'b0;
            ed = ev ? exp_d[cyc] : '0;
            checks++;
            if (rd_valid !== ev || {rd_beat1, rd_beat0} !== ed) begin
                errors++;
                $display("FAIL %s cycle %0d: actual valid=%0b data=%h expected valid=%0b data=%h",
                         cur_req, cyc, rd_valid, {rd_beat1, rd_beat0}, ev, ed);
            end
        end
    end

    task automatic drive(bit ld, bit rw, int a, logic [BW-1:0] b0, logic [BW-1:0] b1);
        @(negedge cmd_clk);
        cmd_ld   = ld;
        cmd_rw   = rw;
        cmd_addr = a[AW-1:0];
        wr_beat0 = b0;
        wr_beat1 = b1;
        if (!rst_m && ld) begin
            if (rw) begin
                exp_v[cyc + 1 + rl_m] = 1'b1;
                exp_d[cyc + 1 + rl_m] = mem_m[a];
            end else begin
                mem_m[a] = {b1, b0};
            end
        end
    endtask

    task automatic nop(int n);
        repeat (n) drive(1'b0, 1'b0, 0, '0, '0);
    endtask

    task automatic wr(int a, logic [BW-1:0] b0, logic [BW-1:0] b1);
        drive(1'b1, 1'b0, a, b0, b1);
    endtask

    task automatic rd(int a);
        drive(1'b1, 1'b1, a, '0, '0);
    endtask

    task automatic set_rst(bit r, bit rl3);
        @(negedge cmd_clk);
        rst     = r;
        rst_m   = r;
        cfg_rl3 = rl3;
        cmd_ld  = 1'b0;
        if (r) rl_m = rl3 ? 3 : 2;
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=still running expected=finished");
            finish_up();
        end
    end

    initial begin
        // R8: commands during the first reset are ignored; R1 idle state
        cur_req = "R8";
        set_rst(1'b1, 1'b0);
        rd(3);
        set_rst(1'b1, 1'b0);
        set_rst(0, 0);
        cur_req = "R1";
        nop(4);

        // R2: two beats stored as one wide word
        cur_req = "R2";
        wr(1, 18'h0A1B2, 18'h3C4D5);
        wr(2, 18'h11111, 18'h22222);
        wr(3, 18'h3FFFF, 18'h00001);
        nop(2);

        // R3: isolated reads, beat order low then high
        cur_req = "R3";
        rd(1); nop(3);
        rd(2); nop(3);
        rd(3); nop(4);

        // R5: back-to-back reads
        cur_req = "R5";
        rd(1); rd(2); rd(3); rd(2);
        nop(5);

        // R6: coherence of write then read
        cur_req = "R6";
        wr(5, 18'h12345, 18'h2ABCD);
        rd(5);
        wr(5, 18'h00F0F, 18'h0F0F0);
        wr(5, 18'h15555, 18'h2AAAA);
        rd(5); rd(5);
        wr(6, 18'h00007, 18'h00008);
        rd(6);
        wr(6, 18'h30303, 18'h04040);
        rd(6);
        nop(5);

        // R7: strobe low is a no-op
        cur_req = "R7";
        drive(1'b0, 1'b0, 1, 18'h3DEAD, 18'h3BEEF);
        drive(1'b0, 1'b1, 2, '0, '0);
        nop(1);
        rd(1);
        nop(5);

        // R10: lowest and highest word addresses
        cur_req = "R10";
        wr(0, 18'h00ABC, 18'h01DEF);
        wr(15, 18'h3F00F, 18'h2C0C0);
        rd(0); rd(15); rd(1);
        nop(5);

        // R8: commands in reset ignored; latency 3 captured
        cur_req = "R8";
        set_rst(1'b1, 1'b1);
        wr(1, 18'h3AAAA, 18'h35555);
        rd(2);
        set_rst(1'b1, 1'b1);
        set_rst(0, 1);
        nop(3);

        // R4: latency three
        cur_req = "R4";
        rd(1); nop(4);
        rd(0); rd(15);
        nop(6);

        // R9: cfg change outside reset has no effect
        cur_req = "R9";
        @(negedge cmd_clk);
        cfg_rl3 = 1'b0;
        cmd_ld  = 1'b0;
        rd(2); nop(2);
        rd(5); wr(7, 18'h0BEEF, 18'h0CAFE); rd(7);
        nop(6);

        // R4: back to latency two
        cur_req = "R4";
        set_rst(1'b1, 1'b0);
        set_rst(0, 0);
        rd(3); rd(7);
        nop(6);

        finish_up();
    end

endmodule